// File: doc/BRIEF.md
# Supply Threshold Crossing Interrupt Monitor

This block watches a digitised supply-voltage code that arrives once per polling cycle. It sorts each code into one of three zones for every threshold channel. Each channel has its own pair of programmable limits. When a channel's zone changes in a direction that the channel is set to watch, the block sets a sticky interrupt-status bit for that channel and can pull an active-low interrupt line. The latest code and the range setting in force for it are kept for software to read. A summary bit tells a serial status word that some interrupt is pending.

The first sample after measurement is switched on is special. It sets every channel's status bit and always raises the interrupt line. The zones found on that sample become the baseline for later comparisons. A pin-mask bit for each channel can keep the line from asserting while the status bits still record events. A read-clear pulse empties all the status bits. The converter, the analog scaling and the serial transport sit outside the block; the block sees only a valid strobe with a code and the clear pulse.

Top module: `supply_xing_irq`

## Requirements
- R1: After reset, result_code, range_q, zone and irq_stat are 0, irq_n is 1 and stat_flag is 0. A sample is taken only on a cycle where both meas_en and smp_valid are 1. A strobe while meas_en is 0 changes no output.
- R2: Each accepted sample loads smp_code into result_code and range_wide into range_q. Codes span 0 to 1023, and 1023 is the saturated top value. range_wide has no effect on zone classification.
- R3: Channel c's zone is held in zone[2c+1:2c]. Its value is 0 when the code is below thr_a[c], 1 when the code is at or above thr_a[c] but below thr_b[c], and 2 when the code is at or above thr_b[c]. It updates only on accepted samples.
- R4: The first accepted sample after meas_en goes to 1 sets every irq_stat bit. It also drives irq_n low whatever edge_mode and pin_en are, and irq_n stays low until the next rd_clr. The zones from this sample become the baseline.
- R5: edge_mode[2c+1:2c] selects channel c's events. 01 fires on a zone increase, 10 on a zone decrease and 11 on either. A sample in the same zone as the previous one produces no event.
- R6: With edge_mode 00, a zone change neither sets the channel's irq_stat bit nor drives irq_n low.
- R7: irq_n is low while any irq_stat[c] with pin_en[c]=1 is set. A status bit whose pin_en is 0 still sets, but it does not drive irq_n.
- R8: irq_stat bits stay set until an rd_clr pulse. If an event occurs in the same cycle as rd_clr, the event's bit ends up set.
- R9: stat_flag is 1 exactly while any irq_stat bit is 1.
- R10: cfg_err is 1 while any channel has thr_b[c] < thr_a[c], and 0 when every thr_b[c] >= thr_a[c], equality included.
- R11: Driving meas_en to 0 forgets the baseline. The next accepted sample after re-enable behaves as a first sample again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_en | input | 1 | Measurement enable |
| range_wide | input | 1 | Range select, stored with each sample |
| smp_valid | input | 1 | Strobe marking a new converted code |
| smp_code | input | W | Converted supply code |
| rd_clr | input | 1 | Clears all interrupt-status bits |
| thr_a | input | NCH*W | Lower threshold of each channel |
| thr_b | input | NCH*W | Upper threshold of each channel |
| edge_mode | input | 2*NCH | Event direction select for each channel |
| pin_en | input | NCH | Per-channel permission to drive irq_n |
| result_code | output | W | Latest accepted code |
| range_q | output | 1 | Range select captured with that code |
| zone | output | 2*NCH | Current zone of each channel |
| irq_stat | output | NCH | Sticky interrupt-status bits |
| irq_n | output | 1 | Active-low interrupt |
| stat_flag | output | 1 | Any interrupt-status bit set |
| cfg_err | output | 1 | Some channel has its upper threshold below its lower one |

## Verification
Every code from 0 to 1023 is fed with events disabled. This separates errors at each threshold boundary, including the saturated top code, from event logic, and it shows that disabled channels stay silent. A sweep over all four edge modes and all nine pairs of source and destination zones tells rising from falling events, and either of them from a same-zone repeat. Dedicated patterns cover the rest: the masked pin against a live status bit, an event and a clear in the same cycle, a strobe while disabled, re-enable after disable, and thresholds that are equal or inverted.

// File: rtl/supxm_pkg.sv
package supxm_pkg;
   typedef enum logic [1:0] {
      ZN_LOW  = 2'd0,
      ZN_MID  = 2'd1,
      ZN_HIGH = 2'd2
   } zone_e;

   localparam int EM_UP_BIT = 0;
   localparam int EM_DN_BIT = 1;
endpackage

// File: rtl/supxm_zone.sv
module supxm_zone
   import supxm_pkg::*;
#(
   parameter int W = 10
) (
   input  logic [W-1:0] code,
   input  logic [W-1:0] lim_lo,
   input  logic [W-1:0] lim_hi,
   output zone_e        zone,
   output logic         bad_cfg
);
   always_comb begin
      if (code >= lim_hi)      zone = ZN_HIGH;
      else if (code >= lim_lo) zone = ZN_MID;
      else                     zone = ZN_LOW;
   end

   assign bad_cfg = (lim_hi < lim_lo);
endmodule

// File: rtl/supxm_chan.sv
module supxm_chan
   import supxm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  logic       first,
   input  zone_e      zone_new,
   input  logic [1:0] mode,
   input  logic       rd_clr,
   output zone_e      zone_q,
   output logic       stat_q
);
   logic went_up, went_dn, evt;

   always_comb begin
      went_up = (zone_new > zone_q);
      went_dn = (zone_new < zone_q);
      evt     = take & (first | (mode[EM_UP_BIT] & went_up) | (mode[EM_DN_BIT] & went_dn));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zone_q <= ZN_LOW;
         stat_q <= 1'b0;
      end else begin
         if (take) zone_q <= zone_new;
         if (evt)         stat_q <= 1'b1;
         else if (rd_clr) stat_q <= 1'b0;
      end
   end
endmodule

// File: rtl/supply_xing_irq.sv
module supply_xing_irq
   import supxm_pkg::*;
#(
   parameter int W   = 10,
   parameter int NCH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             meas_en,
   input  logic             range_wide,
   input  logic             smp_valid,
   input  logic [W-1:0]     smp_code,
   input  logic             rd_clr,
   input  logic [NCH*W-1:0] thr_a,
   input  logic [NCH*W-1:0] thr_b,
   input  logic [2*NCH-1:0] edge_mode,
   input  logic [NCH-1:0]   pin_en,
   output logic [W-1:0]     result_code,
   output logic             range_q,
   output logic [2*NCH-1:0] zone,
   output logic [NCH-1:0]   irq_stat,
   output logic             irq_n,
   output logic             stat_flag,
   output logic             cfg_err
);
   localparam int ZW = 2 * NCH;

   initial begin
      assert (W >= 2 && W <= 16) else $error("supply_xing_irq: W out of range");
      assert (NCH >= 1 && NCH <= 8) else $error("supply_xing_irq: NCH out of range");
   end

   logic           take;
   logic           first_seen;
   logic           boot_pend;
   logic [NCH-1:0] bad_vec;
   logic [ZW-1:0]  zone_flat;

   assign take = meas_en & smp_valid;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      zone_e zn_new;
      zone_e zn_q;

      supxm_zone #(.W(W)) u_zone (
         .code    (smp_code),
         .lim_lo  (thr_a[c*W +: W]),
         .lim_hi  (thr_b[c*W +: W]),
         .zone    (zn_new),
         .bad_cfg (bad_vec[c])
      );

      supxm_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .take     (take),
         .first    (~first_seen),
         .zone_new (zn_new),
         .mode     (edge_mode[2*c +: 2]),
         .rd_clr   (rd_clr),
         .zone_q   (zn_q),
         .stat_q   (irq_stat[c])
      );

      assign zone_flat[2*c +: 2] = zn_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_code <= '0;
         range_q     <= 1'b0;
         first_seen  <= 1'b0;
         boot_pend   <= 1'b0;
      end else begin
         if (take) begin
            result_code <= smp_code;
            range_q     <= range_wide;
         end
         if (!meas_en)  first_seen <= 1'b0;
         else if (take) first_seen <= 1'b1;
         if (take && !first_seen) boot_pend <= 1'b1;
         else if (rd_clr)         boot_pend <= 1'b0;
      end
   end

   assign zone      = zone_flat;
   assign irq_n     = ~(boot_pend | (|(irq_stat & pin_en)));
   assign stat_flag = |irq_stat;
   assign cfg_err   = |bad_vec;
endmodule

module supxm_chk #(
   parameter int W   = 10,
   parameter int NCH = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             meas_en,
   input logic             rd_clr,
   input logic [2*NCH-1:0] edge_mode,
   input logic [W-1:0]     result_code,
   input logic [2*NCH-1:0] zone,
   input logic [NCH-1:0]   irq_stat,
   input logic             irq_n,
   input logic             stat_flag,
   input logic             first_seen
);
   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_en |=> ($stable(result_code) && $stable(zone)));

   // R8
   sticky_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr |=> ((irq_stat & $past(irq_stat)) == $past(irq_stat)));

   // R9
   summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_flag == (irq_stat != '0));

   // R7
   pin_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> (irq_stat != '0));

   // R11
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_en |=> !first_seen);

   for (genvar c = 0; c < NCH; c++) begin : g_off
      // R6
      mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (first_seen && edge_mode[2*c +: 2] == 2'b00 && !irq_stat[c]) |=> !irq_stat[c]);
   end
endmodule

bind supply_xing_irq supxm_chk #(.W(W), .NCH(NCH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .meas_en     (meas_en),
   .rd_clr      (rd_clr),
   .edge_mode   (edge_mode),
   .result_code (result_code),
   .zone        (zone),
   .irq_stat    (irq_stat),
   .irq_n       (irq_n),
   .stat_flag   (stat_flag),
   .first_seen  (first_seen)
);

// File: tb/supply_xing_irq_tb.sv
module supply_xing_irq_tb;
   localparam int W   = 10;
   localparam int NCH = 2;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             meas_en, range_wide, smp_valid, rd_clr;
   logic [W-1:0]     smp_code;
   logic [NCH*W-1:0] thr_a, thr_b;
   logic [2*NCH-1:0] edge_mode;
   logic [NCH-1:0]   pin_en;
   logic [W-1:0]     result_code;
   logic             range_q;
   logic [2*NCH-1:0] zone;
   logic [NCH-1:0]   irq_stat;
   logic             irq_n, stat_flag, cfg_err;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   always #10 clk = ~clk;

   supply_xing_irq #(.W(W), .NCH(NCH)) u_dut (.*);

   task automatic chk(input string rq, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic do_smp(input int c);
      smp_code  = W'(c);
      smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic do_clr();
      rd_clr = 1'b1;
      @(negedge clk);
      rd_clr = 1'b0;
   endtask

   function automatic int zexp(input int c, input int a, input int b);
      if (c >= b) return 2;
      if (c >= a) return 1;
      return 0;
   endfunction

   function automatic int zcode(input int z);
      if (z == 0) return 50;
      if (z == 1) return 500;
      return 950;
   endfunction

   initial begin
      rst_n = 1'b0; meas_en = 1'b0; range_wide = 1'b0; smp_valid = 1'b0; rd_clr = 1'b0;
      smp_code = '0; edge_mode = '0; pin_en = '0;
      thr_a = {10'd100, 10'd300};
      thr_b = {10'd900, 10'd700};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      chk("R1 reset irq_n", irq_n, 1);
      chk("R1 reset irq_stat", irq_stat, 0);
      chk("R1 reset result", result_code, 0);
      chk("R1 reset zone", zone, 0);
      chk("R1 reset range_q", range_q, 0);
      chk("R9 reset stat_flag", stat_flag, 0);
      chk("R10 valid cfg", cfg_err, 0);

      do_smp(500);
      chk("R1 disabled strobe result", result_code, 0);
      chk("R1 disabled strobe stat", irq_stat, 0);
      chk("R1 disabled strobe zone", zone, 0);

      meas_en = 1'b1;
      do_smp(500);
      chk("R4 first stat", irq_stat, 3);
      chk("R4 first irq_n unmasked", irq_n, 0);
      chk("R4 baseline zone", zone, 5);
      chk("R2 first result", result_code, 500);
      chk("R9 flag set", stat_flag, 1);
      do_clr();
      chk("R8 clear stat", irq_stat, 0);
      chk("R4 clear irq_n", irq_n, 1);
      chk("R9 flag clear", stat_flag, 0);

      edge_mode = 4'b1111; pin_en = 2'b11;
      do_smp(520);
      chk("R5 same zone no event", irq_stat, 0);

      // R3 R6 exhaustive code sweep with events off
      edge_mode = 4'b0000;
      for (int c = 0; c < 1024; c++) begin
         do_smp(c);
         chk("R3 zone ch0", zone[1:0], zexp(c, 300, 700));
         chk("R3 zone ch1", zone[3:2], zexp(c, 100, 900));
         chk("R2 result", result_code, c);
         chk("R6 no stat", irq_stat, 0);
         chk("R6 no pin", irq_n, 1);
      end

      range_wide = 1'b1;
      do_smp(700);
      chk("R2 range captured", range_q, 1);
      chk("R2 range no effect on zone", zone[1:0], 2);
      range_wide = 1'b0;
      @(negedge clk);
      chk("R2 range held without sample", range_q, 1);

      // R5 modes x zone pairs
      for (int m = 0; m < 4; m++) begin
         for (int f = 0; f < 3; f++) begin
            for (int t = 0; t < 3; t++) begin
               bit e;
               edge_mode = {2'(m), 2'(m)};
               do_smp(zcode(f));
               do_clr();
               do_smp(zcode(t));
               e = ((t > f) && m[0]) || ((t < f) && m[1]);
               chk($sformatf("R5 mode %0d %0d->%0d stat", m, f, t), irq_stat, e ? 3 : 0);
               chk($sformatf("R5 mode %0d %0d->%0d irq_n", m, f, t), irq_n, e ? 0 : 1);
               do_clr();
            end
         end
      end

      edge_mode = 4'b1111;
      do_smp(950);
      do_clr();
      smp_code = W'(50); smp_valid = 1'b1; rd_clr = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0; rd_clr = 1'b0;
      chk("R8 event beats clear", irq_stat, 3);
      do_clr();
      chk("R8 plain clear", irq_stat, 0);

      edge_mode = 4'b1100; pin_en = 2'b01;
      do_smp(950);
      chk("R7 masked stat set", irq_stat, 2);
      chk("R7 masked pin idle", irq_n, 1);
      chk("R9 flag with masked bit", stat_flag, 1);
      pin_en = 2'b11;
      #1;
      chk("R7 unmask asserts pin", irq_n, 0);
      do_clr();

      meas_en = 1'b0;
      @(negedge clk);
      do_smp(500);
      chk("R1 strobe while off", result_code, 950);
      chk("R1 strobe while off stat", irq_stat, 0);
      meas_en = 1'b1; edge_mode = 4'b0000; pin_en = 2'b00;
      do_smp(950);
      chk("R11 rearm stat", irq_stat, 3);
      chk("R11 rearm irq_n", irq_n, 0);
      do_clr();
      chk("R11 rearm cleared", irq_n, 1);

      thr_b = {10'd99, 10'd700};
      #1;
      chk("R10 inverted thresholds", cfg_err, 1);
      thr_b = {10'd100, 10'd700};
      #1;
      chk("R10 equal thresholds", cfg_err, 0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule